// File: doc/BRIEF.md
# Indexed Address and Branch Sequencer

This block runs the bus-cycle sequence that an 8-bit processor needs for two kinds of operation. The first is absolute-indexed addressing, where a 16-bit base is fetched from the instruction stream and an index register value is added to it. The second is the relative branch, where a signed 8-bit displacement is fetched and, if the branch is taken, added to the program counter. Each bus access takes one clock, and dummy accesses count the same as real ones. When a sum crosses into a different 256-byte page, the block issues one extra dummy read. The address of that read depends on a variant input: the older silicon reads the half-formed address, and the newer silicon re-reads the program counter.

A caller pulses `start` while the block is idle and supplies the program counter, the kind of operation, the variant, the index value, the branch condition and a flag for operations that always spend the extra cycle (stores and read-modify-writes). The block drives a simple read port. After the last access it pulses `done` and presents the resolved address, the updated program counter and the number of bus cycles used. These values are held until the next request.

Top module: `idx_branch_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `bus_rd` and `done` are 0.
- R2: An indexed request (`mode_branch`=0) reads the low base byte at PC and then the high byte at PC+1. `res_addr` is the base plus the zero-extended index, modulo 2^16. `pc_next` is PC+2, modulo 2^16.
- R3: On an indexed page crossing (the high byte of the sum differs from the base high byte) with `cmos_mode`=0, the third read is at {base high byte, low byte of the sum}. `cycles` is 3.
- R4: On an indexed page crossing with `cmos_mode`=1, the third read is at PC+2 (the advanced PC). `cycles` is 3.
- R5: An indexed request with no crossing and `always_extra`=0 makes exactly two reads, and `cycles` is 2.
- R6: With `always_extra`=1 and no crossing, a third read is made at the true effective address. With a crossing, only the single page-fix read of R3 or R4 is made. In both cases `cycles` is 3.
- R7: A branch request (`mode_branch`=1) with `branch_take`=0 makes one read at PC. `cycles` is 1, and `pc_next` and `res_addr` are PC+1.
- R8: A taken branch makes a second read at PC+1. The target is PC+1 plus the sign-extended displacement. Without a page change `cycles` is 2.
- R9: A taken branch whose target lies in a different page from PC+1 makes a third read. That read is at {high byte of PC+1, low byte of target} when `cmos_mode`=0, and at PC+1 when `cmos_mode`=1. `cycles` is 3.
- R10: Sums wrap modulo 2^16. A wrap through 0xFFFF counts as a page crossing.
- R11: `done` is a one-cycle pulse in the cycle after the last access. `cycles`, `res_addr` and `pc_next` hold their values after the pulse. A `start` asserted while `busy` is 1 is ignored.
- R12: `bus_rd` is high for exactly `cycles` consecutive clocks, beginning the clock after `start` is accepted. `bus_rdata` is sampled at the end of each such clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken only while idle |
| mode_branch | input | 1 | 0 = absolute-indexed, 1 = relative branch |
| cmos_mode | input | 1 | 0 = older dummy-read variant, 1 = newer variant |
| always_extra | input | 1 | Operation always spends the extra indexed cycle |
| index_val | input | 8 | Index register value |
| branch_take | input | 1 | Branch condition is true |
| pc_in | input | 16 | Program counter at the first operand byte |
| bus_addr | output | 16 | Read address |
| bus_rd | output | 1 | Read strobe, one clock per access |
| bus_rdata | input | 8 | Read data for the current access |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| cycles | output | 4 | Bus cycles used by the last sequence |
| res_addr | output | 16 | Effective address (indexed) or new PC (branch) |
| pc_next | output | 16 | Program counter after the sequence |

## Verification
Two functions can fall in the same cycle: the page-fix dummy read and the always-extra dummy read. Both compete for the third access of an indexed request. The bench sets `always_extra` on a request whose sum also crosses a page. It then checks that exactly one third read occurs, that it lands on the page-fix address chosen by the variant and not on the effective address, and that `cycles` stays at 3. A second overlap is a new `start` raised in the middle of a sequence. The bench checks that this start leaves the address trace and results of the running request untouched.

// File: rtl/ixb_pkg.sv
package ixb_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPLO,
      ST_OPHI,
      ST_IXFIX,
      ST_IXEXTRA,
      ST_BROFF,
      ST_BRTAKE,
      ST_BRFIX
   } seq_state_e;
endpackage

// File: rtl/ixb_page_adder.sv
// Adds an offset to a base and reports the page-local provisional result.
module ixb_page_adder #(
   parameter int ADDR_W     = 16,
   parameter int OFF_W      = 8,
   parameter bit SIGNED_OFF = 1'b0
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [OFF_W-1:0]  offset,
   output logic [ADDR_W-1:0] sum,
   output logic [ADDR_W-1:0] provisional,
   output logic              crossed
);
   localparam int EXT_W = ADDR_W - OFF_W;

   logic [ADDR_W-1:0] off_ext;

   generate
      if (SIGNED_OFF) begin : g_sext
         assign off_ext = {{EXT_W{offset[OFF_W-1]}}, offset};
      end else begin : g_zext
         assign off_ext = {{EXT_W{1'b0}}, offset};
      end
   endgenerate

   assign sum         = base + off_ext;
   assign provisional = {base[ADDR_W-1:OFF_W], sum[OFF_W-1:0]};
   assign crossed     = (sum[ADDR_W-1:OFF_W] != base[ADDR_W-1:OFF_W]);
endmodule

// File: rtl/ixb_cycle_ctr.sv
// Counts bus accesses of the current sequence.
module ixb_cycle_ctr #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] count
);
   always_ff @(posedge clk) begin
      if (!rst_n)   count <= '0;
      else if (clr) count <= '0;
      else if (inc) count <= count + W'(1);
   end
endmodule

// File: rtl/idx_branch_seq.sv
module idx_branch_seq
   import ixb_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              mode_branch,
   input  logic              cmos_mode,
   input  logic              always_extra,
   input  logic [DATA_W-1:0] index_val,
   input  logic              branch_take,
   input  logic [ADDR_W-1:0] pc_in,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_rd,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              busy,
   output logic              done,
   output logic [CNT_W-1:0]  cycles,
   output logic [ADDR_W-1:0] res_addr,
   output logic [ADDR_W-1:0] pc_next
);
   localparam int PAGE_HI = ADDR_W - 1;
   localparam int PAGE_LO = DATA_W;
   localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

   generate
      if (ADDR_W != 2 * DATA_W) begin : g_bad_width
         $error("idx_branch_seq: ADDR_W must be twice DATA_W");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("idx_branch_seq: CNT_W must hold the value 3");
      end
   endgenerate

   seq_state_e        st;
   logic [ADDR_W-1:0] pc_q, eff_q, prov_q, res_q, pcn_q;
   logic [DATA_W-1:0] lo_q, idx_q, off_q;
   logic              cmos_q, always_q, take_q, done_q;
   logic              accept;

   logic [ADDR_W-1:0] ix_sum, ix_prov, br_sum, br_prov;
   logic              ix_cross, br_cross;

   assign accept = start && (st == ST_IDLE);

   ixb_page_adder #(.ADDR_W(ADDR_W), .OFF_W(DATA_W), .SIGNED_OFF(1'b0)) i_ix_add (
      .base        ({bus_rdata, lo_q}),
      .offset      (idx_q),
      .sum         (ix_sum),
      .provisional (ix_prov),
      .crossed     (ix_cross)
   );

   ixb_page_adder #(.ADDR_W(ADDR_W), .OFF_W(DATA_W), .SIGNED_OFF(1'b1)) i_br_add (
      .base        (pc_q),
      .offset      (off_q),
      .sum         (br_sum),
      .provisional (br_prov),
      .crossed     (br_cross)
   );

   ixb_cycle_ctr #(.W(CNT_W)) i_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (accept),
      .inc   (bus_rd),
      .count (cycles)
   );

   always_comb begin
      bus_rd   = 1'b1;
      bus_addr = pc_q;
      unique case (st)
         ST_OPLO, ST_OPHI, ST_BROFF, ST_BRTAKE: bus_addr = pc_q;
         ST_IXFIX, ST_BRFIX:                    bus_addr = cmos_q ? pc_q : prov_q;
         ST_IXEXTRA:                            bus_addr = eff_q;
         default: begin
            bus_rd   = 1'b0;
            bus_addr = '0;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         pc_q     <= '0;
         eff_q    <= '0;
         prov_q   <= '0;
         res_q    <= '0;
         pcn_q    <= '0;
         lo_q     <= '0;
         idx_q    <= '0;
         off_q    <= '0;
         cmos_q   <= 1'b0;
         always_q <= 1'b0;
         take_q   <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (start) begin
                  pc_q     <= pc_in;
                  idx_q    <= index_val;
                  cmos_q   <= cmos_mode;
                  always_q <= always_extra;
                  take_q   <= branch_take;
                  st       <= mode_branch ? ST_BROFF : ST_OPLO;
               end
            end
            ST_OPLO: begin
               lo_q <= bus_rdata;
               pc_q <= pc_q + ONE;
               st   <= ST_OPHI;
            end
            ST_OPHI: begin
               pc_q   <= pc_q + ONE;
               eff_q  <= ix_sum;
               prov_q <= ix_prov;
               if (ix_cross)      st <= ST_IXFIX;
               else if (always_q) st <= ST_IXEXTRA;
               else begin
                  st     <= ST_IDLE;
                  done_q <= 1'b1;
                  res_q  <= ix_sum;
                  pcn_q  <= pc_q + ONE;
               end
            end
            ST_IXFIX, ST_IXEXTRA: begin
               st     <= ST_IDLE;
               done_q <= 1'b1;
               res_q  <= eff_q;
               pcn_q  <= pc_q;
            end
            ST_BROFF: begin
               off_q <= bus_rdata;
               pc_q  <= pc_q + ONE;
               if (take_q) st <= ST_BRTAKE;
               else begin
                  st     <= ST_IDLE;
                  done_q <= 1'b1;
                  res_q  <= pc_q + ONE;
                  pcn_q  <= pc_q + ONE;
               end
            end
            ST_BRTAKE: begin
               eff_q  <= br_sum;
               prov_q <= br_prov;
               if (br_cross) st <= ST_BRFIX;
               else begin
                  st     <= ST_IDLE;
                  done_q <= 1'b1;
                  res_q  <= br_sum;
                  pcn_q  <= br_sum;
               end
            end
            ST_BRFIX: begin
               st     <= ST_IDLE;
               done_q <= 1'b1;
               res_q  <= eff_q;
               pcn_q  <= eff_q;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (st != ST_IDLE);
   assign done     = done_q;
   assign res_addr = res_q;
   assign pc_next  = pcn_q;

   // R12: every strobed clock adds exactly one to the cycle count
   a_r12_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |=> (cycles == $past(cycles) + CNT_W'(1)));

   // R11: completion is a single-cycle pulse and the block is idle then
   a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r11_idle_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R3: the older-variant fix read stays in the base page, not the true page
   a_r3_fix_wrong_page: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IXFIX && !cmos_q) |-> (bus_addr[PAGE_HI:PAGE_LO] != eff_q[PAGE_HI:PAGE_LO]));

   // R9: the older-variant branch fix read stays in the pre-branch page
   a_r9_branch_fix_page: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_BRFIX && !cmos_q) |-> (bus_addr[PAGE_HI:PAGE_LO] == pc_q[PAGE_HI:PAGE_LO]));

   // R7: an untaken branch finishes after a single access
   a_r7_untaken_one: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_BROFF && !take_q) |=> (done && cycles == CNT_W'(1)));

   // R6: no sequence ever exceeds three accesses
   a_r6_cycle_bound: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cycles >= CNT_W'(1) && cycles <= CNT_W'(3)));
endmodule

// File: tb/test_idx_branch_seq.sv
`timescale 1ns/1ps
module test_idx_branch_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, mode_branch = 1'b0, cmos_mode = 1'b0, always_extra = 1'b0;
   logic [7:0]  index_val = '0;
   logic        branch_take = 1'b0;
   logic [15:0] pc_in = '0;
   logic [15:0] bus_addr;
   logic        bus_rd;
   logic [7:0]  bus_rdata;
   logic        busy, done;
   logic [3:0]  cycles;
   logic [15:0] res_addr, pc_next;

   logic [15:0] ov_a0 = '0, ov_a1 = '0;
   logic [7:0]  ov_d0 = '0, ov_d1 = '0;
   int nchk = 0, nerr = 0;

   always #5 clk = ~clk;

   assign bus_rdata = (bus_addr == ov_a0) ? ov_d0 :
                      (bus_addr == ov_a1) ? ov_d1 :
                      (bus_addr[7:0] ^ bus_addr[15:8] ^ 8'hA5);

   idx_branch_seq i_idx_branch_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .mode_branch(mode_branch),
      .cmos_mode(cmos_mode), .always_extra(always_extra), .index_val(index_val),
      .branch_take(branch_take), .pc_in(pc_in), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_rdata(bus_rdata), .busy(busy), .done(done), .cycles(cycles),
      .res_addr(res_addr), .pc_next(pc_next)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run(input string tag, input logic br, input logic cm, input logic ax,
                      input logic [7:0] idx, input logic tk, input logic [15:0] pc,
                      input logic [7:0] b0, input logic [7:0] b1, input int en,
                      input logic [15:0] e0, input logic [15:0] e1, input logic [15:0] e2,
                      input logic [15:0] eres, input logic [15:0] epcn);
      logic [15:0] tr [4];
      logic [15:0] ex;
      int n;
      bit got;
      ov_a0 = pc; ov_d0 = b0; ov_a1 = pc + 16'd1; ov_d1 = b1;
      @(negedge clk);
      mode_branch = br; cmos_mode = cm; always_extra = ax; index_val = idx;
      branch_take = tk; pc_in = pc; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n = 0; got = 1'b0;
      for (int k = 0; k < 12 && !got; k++) begin
         if (bus_rd) begin
            if (n < 4) tr[n] = bus_addr;
            n++;
         end
         if (done) got = 1'b1;
         else @(negedge clk);
      end
      chk({tag, " R11 done seen"}, 16'(got), 16'd1);
      chk({tag, " R12 strobe count"}, 16'(n), 16'(en));
      for (int i = 0; i < en && i < 4; i++) begin
         ex = (i == 0) ? e0 : (i == 1) ? e1 : e2;
         chk({tag, $sformatf(" R12 access %0d addr", i)}, tr[i], ex);
      end
      chk({tag, " R12 cycles"}, 16'(cycles), 16'(en));
      chk({tag, " R2 result"}, res_addr, eres);
      chk({tag, " R2 pc_next"}, pc_next, epcn);
      @(negedge clk);
      chk({tag, " R11 pulse ends"}, 16'(done), 16'd0);
      chk({tag, " R11 cycles held"}, 16'(cycles), 16'(en));
   endtask

   task automatic t_reset();
      chk("R1 busy", 16'(busy), 16'd0);
      chk("R1 bus_rd", 16'(bus_rd), 16'd0);
      chk("R1 done", 16'(done), 16'd0);
   endtask

   task automatic t_busy_start();
      ov_a0 = 16'h1200; ov_d0 = 8'h40; ov_a1 = 16'h1201; ov_d1 = 8'h30;
      @(negedge clk);
      mode_branch = 1'b0; cmos_mode = 1'b0; always_extra = 1'b0; index_val = 8'h10;
      pc_in = 16'h1200; start = 1'b1;
      @(negedge clk);
      mode_branch = 1'b1; pc_in = 16'h5555;
      chk("R11 first read addr", bus_addr, 16'h1200);
      @(negedge clk);
      start = 1'b0;
      chk("R11 second read addr", bus_addr, 16'h1201);
      @(negedge clk);
      chk("R11 done after busy start", 16'(done), 16'd1);
      chk("R11 busy start ignored result", res_addr, 16'h3050);
      chk("R11 busy start ignored pc", pc_next, 16'h1202);
      @(negedge clk);
      chk("R11 no second sequence", 16'(bus_rd | busy), 16'd0);
   endtask

   initial begin
      #2_000_000;
      nerr++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      // R2 R5: no crossing, two reads
      run("R5 ix nocross", 0, 0, 0, 8'h10, 0, 16'h1200, 8'h40, 8'h30, 2,
          16'h1200, 16'h1201, 16'h0000, 16'h3050, 16'h1202);
      // R3: older variant page crossing
      run("R3 ix cross nmos", 0, 0, 0, 8'h20, 0, 16'h1200, 8'hF0, 8'h30, 3,
          16'h1200, 16'h1201, 16'h3010, 16'h3110, 16'h1202);
      // R4: newer variant page crossing
      run("R4 ix cross cmos", 0, 1, 0, 8'h20, 0, 16'h1200, 8'hF0, 8'h30, 3,
          16'h1200, 16'h1201, 16'h1202, 16'h3110, 16'h1202);
      // R6: always-extra without crossing reads the effective address
      run("R6 ix extra nocross", 0, 0, 1, 8'h10, 0, 16'h0800, 8'h40, 8'h30, 3,
          16'h0800, 16'h0801, 16'h3050, 16'h3050, 16'h0802);
      // R6: always-extra with crossing spends only the fix read
      run("R6 ix extra cross nmos", 0, 0, 1, 8'h20, 0, 16'h0800, 8'hF0, 8'h30, 3,
          16'h0800, 16'h0801, 16'h3010, 16'h3110, 16'h0802);
      run("R6 ix extra cross cmos", 0, 1, 1, 8'h20, 0, 16'h0800, 8'hF0, 8'h30, 3,
          16'h0800, 16'h0801, 16'h0802, 16'h3110, 16'h0802);
      // R10: wrap of both the sum and the PC
      run("R10 ix wrap", 0, 0, 0, 8'h20, 0, 16'hFFFE, 8'hF0, 8'hFF, 3,
          16'hFFFE, 16'hFFFF, 16'hFF10, 16'h0010, 16'h0000);
      // R7: untaken branch
      run("R7 br untaken", 1, 0, 0, 8'h00, 0, 16'h2000, 8'h05, 8'h00, 1,
          16'h2000, 16'h0000, 16'h0000, 16'h2001, 16'h2001);
      // R8: taken forward and backward within the page
      run("R8 br fwd same", 1, 0, 0, 8'h00, 1, 16'h2010, 8'h05, 8'h00, 2,
          16'h2010, 16'h2011, 16'h0000, 16'h2016, 16'h2016);
      run("R8 br back same", 1, 1, 0, 8'h00, 1, 16'h2040, 8'hF0, 8'h00, 2,
          16'h2040, 16'h2041, 16'h0000, 16'h2031, 16'h2031);
      // R9: taken across a page, both variants
      run("R9 br back cross nmos", 1, 0, 0, 8'h00, 1, 16'h2005, 8'hF0, 8'h00, 3,
          16'h2005, 16'h2006, 16'h20F6, 16'h1FF6, 16'h1FF6);
      run("R9 br fwd cross cmos", 1, 1, 0, 8'h00, 1, 16'h20F0, 8'h7F, 8'h00, 3,
          16'h20F0, 16'h20F1, 16'h20F1, 16'h2170, 16'h2170);
      // R11: start raised mid-sequence
      t_busy_start();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule